// File: doc/BRIEF.md
# Microcode Control Sequencer with Falling-Edge Address Timing

This block is the control unit of a small bus-based processor. A step counter and an opcode register together address an internal microcode table. The table's output word drives the control lines of the datapath. Every input of that address moves only on the falling clock edge, so the control word cannot change while the clock is high. Two kinds of target can therefore use it safely: registers that load on the rising edge when their enable bit is set, and edge-triggered targets that only see a gated clock.

The opcode register has two stages. The first stage takes the opcode from the bus on the rising edge of step T1. The second stage copies the first on every falling edge, and only the second stage feeds the table. Conditional jumps are not encoded through the table address. Jump-type bits from the word are combined with the flags in separate logic to produce the program-counter load. For write strobes, stack clocks and flag clocks, the block ANDs a control bit with the system clock.

Top module: `ucode_sequencer`

## Requirements
- R1: An active-high synchronous reset clears the step count and both opcode stages. During reset the step output is 0 and the control word is the T0 fetch word 0x0003.
- R2: The step count changes only on a falling clock edge and otherwise increments by one. For every opcode, step T0 gives word 0x0003 (bit 0 pc_out, bit 1 mar_in) and step T1 gives 0x001C (bit 2 mem_out, bit 3 op_load, bit 4 pc_inc).
- R3: With no early return, the count runs T0 to T7 and then wraps to T0. Opcode 8 gives 0x0800 in T2 and 0x0000 in T3 to T7.
- R4: When bit 15 (step_clr) is set in a step, the next falling edge returns the count to T0. Opcode 0 asserts it in T2.
- R5: The first opcode stage loads bus_in on a rising edge only while bit 3 is set, which happens in T1. Bus changes at any other time do not alter the opcode-dependent words.
- R6: The table is addressed only by the step count and the second opcode stage. The control word is identical across each whole high phase.
- R7: The flags never affect the control word.
- R8: pc_load is high when bit 14 (jump always) is set, or when bit 12 is set and flags_in[0] (carry) is high, or when bit 13 is set and flags_in[1] (zero) is high. It is low otherwise.
- R9: gclk[0], gclk[1] and gclk[2] are the AND of the clock with bit 9 (mem_write), bit 10 (stack_step) and bit 11 (flag_load). Each gives exactly one pulse in a step that sets its bit and none in other steps.
- R10: The opcode-dependent words are as follows. Opcode 1: T2 0x0003, T3 0x0034, T4 0x8000. Opcode 2: T2 0x0920, T3 0x8000. Opcode 3: T2 0x0240, T3 0x8000. Opcode 4: T2 0x0003, T3 0x4004, T4 0x8000. Opcode 5: T2 0x0003, T3 0x1004, T4 0x8000. Opcode 6: T2 0x0003, T3 0x2004, T4 0x8000. Opcode 7: T2 0x0440, T3 0x8000. Opcodes 9 to 15: T2 0x8000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high synchronous reset |
| bus_in | input | OP_W | Opcode as seen on the data bus |
| flags_in | input | 2 | Bit 0 carry, bit 1 zero |
| step | output | STEP_W | Current microstep |
| ctrl_word | output | 16 | Control word from the microcode table |
| pc_load | output | 1 | Program-counter load from the jump decision |
| gclk | output | 3 | Gated clocks for edge-only targets |

## Verification
The hardest situation to reach is the one the two-stage opcode register exists for: the new opcode is captured on a rising edge while the clock is high. The table address must still not move until the following falling edge. The stimulus holds the opcode on the bus through the T1 capture edge and replaces it with a different opcode right after that edge. It also changes the flags in the middle of jump instructions. On every cycle the bench compares the word seen late in the low phase with the word seen during the following high phase. On every cycle it also counts the pulses on each gated clock.

// File: rtl/useq_pkg.sv
package useq_pkg;
   localparam int CTRL_W = 16;
   localparam int FLAG_W = 2;
   localparam int N_GATE = 3;

   // control bit positions
   localparam int CB_PC_OUT   = 0;
   localparam int CB_MAR_IN   = 1;
   localparam int CB_MEM_OUT  = 2;
   localparam int CB_OP_LOAD  = 3;
   localparam int CB_PC_INC   = 4;
   localparam int CB_A_IN     = 5;
   localparam int CB_A_OUT    = 6;
   localparam int CB_B_IN     = 7;
   localparam int CB_ALU_OUT  = 8;
   localparam int CB_MEM_WR   = 9;
   localparam int CB_STK_STEP = 10;
   localparam int CB_FLAG_LD  = 11;
   localparam int CB_JMP_CY   = 12;
   localparam int CB_JMP_ZR   = 13;
   localparam int CB_JMP_ALL  = 14;
   localparam int CB_STEP_CLR = 15;

   localparam int FL_CARRY = 0;
   localparam int FL_ZERO  = 1;

   function automatic logic [CTRL_W-1:0] bw(input int b);
      logic [CTRL_W-1:0] v;
      v    = '0;
      v[b] = 1'b1;
      return v;
   endfunction

   // which control bit each gated clock follows
   function automatic int gate_bit(input int g);
      case (g)
         0:       return CB_MEM_WR;
         1:       return CB_STK_STEP;
         default: return CB_FLAG_LD;
      endcase
   endfunction
endpackage

// File: rtl/useq_step_ctr.sv
module useq_step_ctr #(
   parameter int N_STEPS = 8,
   localparam int STEP_W = $clog2(N_STEPS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr,
   output logic [STEP_W-1:0] step
);
   localparam logic [STEP_W-1:0] LAST = STEP_W'(N_STEPS - 1);

   generate
      if ((N_STEPS & (N_STEPS - 1)) == 0) begin : g_pow2
         always_ff @(negedge clk) begin
            if (rst || clr) step <= '0;
            else            step <= step + 1'b1;
         end
      end else begin : g_cmp
         always_ff @(negedge clk) begin
            if (rst || clr || step == LAST) step <= '0;
            else                            step <= step + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/useq_op_reg.sv
module useq_op_reg #(
   parameter int OP_W = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            load,
   input  logic [OP_W-1:0] bus_in,
   output logic [OP_W-1:0] op_addr
);
   logic [OP_W-1:0] op_rise;

   always_ff @(posedge clk) begin
      if (rst)       op_rise <= '0;
      else if (load) op_rise <= bus_in;
   end

   always_ff @(negedge clk) begin
      if (rst) op_addr <= '0;
      else     op_addr <= op_rise;
   end
endmodule

// File: rtl/useq_rom.sv
module useq_rom #(
   parameter int OP_W   = 4,
   parameter int STEP_W = 3
) (
   input  logic [STEP_W-1:0]             step,
   input  logic [OP_W-1:0]               op,
   output logic [useq_pkg::CTRL_W-1:0]   word
);
   import useq_pkg::*;

   localparam logic [CTRL_W-1:0] W_FETCH = bw(CB_PC_OUT) | bw(CB_MAR_IN);
   localparam logic [CTRL_W-1:0] W_DECO  = bw(CB_MEM_OUT) | bw(CB_OP_LOAD) | bw(CB_PC_INC);
   localparam logic [CTRL_W-1:0] W_DONE  = bw(CB_STEP_CLR);

   always_comb begin
      word = '0;
      case (int'(step))
         0: word = W_FETCH;
         1: word = W_DECO;
         default: begin
            case (int'(op))
               1: case (int'(step))
                     2: word = W_FETCH;
                     3: word = bw(CB_MEM_OUT) | bw(CB_A_IN) | bw(CB_PC_INC);
                     4: word = W_DONE;
                     default: word = '0;
                  endcase
               2: case (int'(step))
                     2: word = bw(CB_ALU_OUT) | bw(CB_A_IN) | bw(CB_FLAG_LD);
                     3: word = W_DONE;
                     default: word = '0;
                  endcase
               3: case (int'(step))
                     2: word = bw(CB_A_OUT) | bw(CB_MEM_WR);
                     3: word = W_DONE;
                     default: word = '0;
                  endcase
               4, 5, 6: case (int'(step))
                     2: word = W_FETCH;
                     3: word = bw(CB_MEM_OUT) |
                               ((int'(op) == 4) ? bw(CB_JMP_ALL) :
                                (int'(op) == 5) ? bw(CB_JMP_CY) : bw(CB_JMP_ZR));
                     4: word = W_DONE;
                     default: word = '0;
                  endcase
               7: case (int'(step))
                     2: word = bw(CB_A_OUT) | bw(CB_STK_STEP);
                     3: word = W_DONE;
                     default: word = '0;
                  endcase
               8: word = (int'(step) == 2) ? bw(CB_FLAG_LD) : '0;
               default: word = (int'(step) == 2) ? W_DONE : '0;
            endcase
         end
      endcase
   end
endmodule

// File: rtl/useq_gate.sv
module useq_gate #(
   parameter int N_GATE = 3
) (
   input  logic                          clk,
   input  logic [useq_pkg::CTRL_W-1:0]   word,
   output logic [N_GATE-1:0]             gclk
);
   generate
      for (genvar g = 0; g < N_GATE; g++) begin : g_and
         assign gclk[g] = word[useq_pkg::gate_bit(g)] & clk;
      end
   endgenerate
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer #(
   parameter int OP_W    = 4,
   parameter int N_STEPS = 8,
   localparam int STEP_W = $clog2(N_STEPS),
   localparam int CTRL_W = useq_pkg::CTRL_W,
   localparam int FLAG_W = useq_pkg::FLAG_W,
   localparam int N_GATE = useq_pkg::N_GATE
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [OP_W-1:0]   bus_in,
   input  logic [FLAG_W-1:0] flags_in,
   output logic [STEP_W-1:0] step,
   output logic [CTRL_W-1:0] ctrl_word,
   output logic              pc_load,
   output logic [N_GATE-1:0] gclk
);
   import useq_pkg::*;

   generate
      if (OP_W < 4)      begin : g_bad_op   $error("OP_W must be at least 4"); end
      if (N_STEPS < 8)   begin : g_bad_lo   $error("N_STEPS must be at least 8"); end
      if (N_STEPS > 64)  begin : g_bad_hi   $error("N_STEPS too large"); end
   endgenerate

   logic [OP_W-1:0] op_addr;

   useq_step_ctr #(.N_STEPS(N_STEPS)) u_step (
      .clk (clk),
      .rst (rst),
      .clr (ctrl_word[CB_STEP_CLR]),
      .step(step)
   );

   useq_op_reg #(.OP_W(OP_W)) u_op (
      .clk    (clk),
      .rst    (rst),
      .load   (ctrl_word[CB_OP_LOAD]),
      .bus_in (bus_in),
      .op_addr(op_addr)
   );

   useq_rom #(.OP_W(OP_W), .STEP_W(STEP_W)) u_rom (
      .step(step),
      .op  (op_addr),
      .word(ctrl_word)
   );

   useq_gate #(.N_GATE(N_GATE)) u_gate (
      .clk (clk),
      .word(ctrl_word),
      .gclk(gclk)
   );

   // jump decision kept outside the table address
   always_comb begin
      pc_load = ctrl_word[CB_JMP_ALL]
              | (ctrl_word[CB_JMP_CY] & flags_in[FL_CARRY])
              | (ctrl_word[CB_JMP_ZR] & flags_in[FL_ZERO]);
   end
endmodule

// File: rtl/useq_checker.sv
module useq_checker #(
   parameter int N_STEPS = 8,
   parameter int STEP_W  = 3,
   parameter int CTRL_W  = 16,
   parameter int N_GATE  = 3
) (
   input logic              clk,
   input logic              rst,
   input logic [STEP_W-1:0] step,
   input logic [CTRL_W-1:0] ctrl_word,
   input logic              pc_load,
   input logic [N_GATE-1:0] gclk
);
   import useq_pkg::*;

   logic              hi_valid;
   logic [CTRL_W-1:0] word_at_rise;
   logic [STEP_W-1:0] step_at_rise;

   always_ff @(posedge clk) begin
      if (rst) begin
         hi_valid     <= 1'b0;
         word_at_rise <= '0;
         step_at_rise <= '0;
      end else begin
         hi_valid     <= 1'b1;
         word_at_rise <= ctrl_word;
         step_at_rise <= step;
      end
   end

   p_reset_fetch_r1: assert property (@(negedge clk)
      rst |=> (step == '0) && ctrl_word[CB_PC_OUT] && ctrl_word[CB_MAR_IN]);

   p_step_high_stable_r2: assert property (@(negedge clk) disable iff (rst)
      hi_valid |-> step == step_at_rise);

   p_step_advance_r2: assert property (@(negedge clk) disable iff (rst)
      (!ctrl_word[CB_STEP_CLR] && step != STEP_W'(N_STEPS - 1))
         |=> step == STEP_W'($past(step) + 1'b1));

   p_step_wrap_r3: assert property (@(negedge clk) disable iff (rst)
      (step == STEP_W'(N_STEPS - 1)) |=> step == '0);

   p_step_clear_r4: assert property (@(negedge clk) disable iff (rst)
      ctrl_word[CB_STEP_CLR] |=> step == '0);

   p_word_high_stable_r6: assert property (@(negedge clk) disable iff (rst)
      hi_valid |-> ctrl_word == word_at_rise);

   p_no_jump_bits_r8: assert property (@(posedge clk) disable iff (rst)
      (!ctrl_word[CB_JMP_ALL] && !ctrl_word[CB_JMP_CY] && !ctrl_word[CB_JMP_ZR])
         |-> !pc_load);

   generate
      for (genvar g = 0; g < N_GATE; g++) begin : g_gate_chk
         p_gate_follow_r9: assert property (@(negedge clk) disable iff (rst)
            gclk[g] == ctrl_word[gate_bit(g)]);
         p_gate_low_r9: assert property (@(posedge clk) disable iff (rst)
            !gclk[g]);
      end
   endgenerate
endmodule

bind ucode_sequencer useq_checker #(
   .N_STEPS(N_STEPS),
   .STEP_W (STEP_W),
   .CTRL_W (CTRL_W),
   .N_GATE (N_GATE)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .step     (step),
   .ctrl_word(ctrl_word),
   .pc_load  (pc_load),
   .gclk     (gclk)
);

// File: tb/sim_ucode_sequencer.sv
`timescale 1ns/1ps
module sim_ucode_sequencer;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  bus_in = '0;
   logic [1:0]  flags_in = '0;
   logic [2:0]  step;
   logic [15:0] ctrl_word;
   logic        pc_load;
   logic [2:0]  gclk;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   bit mon_on = 1'b0;

   always #4 clk = ~clk;

   ucode_sequencer u0 (
      .clk(clk), .rst(rst), .bus_in(bus_in), .flags_in(flags_in),
      .step(step), .ctrl_word(ctrl_word), .pc_load(pc_load), .gclk(gclk)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // per-cycle monitors: word stability and gated clock pulse counts
   logic [15:0] lo_word;
   int gcnt0 = 0, gcnt1 = 0, gcnt2 = 0;
   int tot0 = 0, tot1 = 0, tot2 = 0;

   always @(posedge gclk[0]) begin gcnt0++; tot0++; end
   always @(posedge gclk[1]) begin gcnt1++; tot1++; end
   always @(posedge gclk[2]) begin gcnt2++; tot2++; end

   always @(negedge clk) begin
      #1; gcnt0 = 0; gcnt1 = 0; gcnt2 = 0;
      #2; lo_word = ctrl_word;
   end

   always @(posedge clk) begin
      #1;
      if (mon_on) check("R6", "word early high", ctrl_word, lo_word);
      #2;
      if (mon_on) begin
         check("R6", "word late high", ctrl_word, lo_word);
         check("R9", "gclk0 pulses", gcnt0, lo_word[9]  ? 1 : 0);
         check("R9", "gclk1 pulses", gcnt1, lo_word[10] ? 1 : 0);
         check("R9", "gclk2 pulses", gcnt2, lo_word[11] ? 1 : 0);
      end
   end

   // called in a low phase; checks the high phase of that step
   task automatic step_chk(input int s, input logic [15:0] w, input bit pl, input string req);
      @(posedge clk); #2;
      check(req, "step", step, s);
      check(req, "word", ctrl_word, w);
      check("R8", "pc_load", pc_load, pl);
      @(negedge clk); #1;
   endtask

   task automatic fetch_chk(input logic [3:0] op);
      bus_in = op;
      tot0 = 0; tot1 = 0; tot2 = 0;
      step_chk(0, 16'h0003, 0, "R2");
      step_chk(1, 16'h001C, 0, "R2");
   endtask

   task automatic back_to_t0(input string req);
      check(req, "return to T0", step, 0);
   endtask

   task automatic t_reset;
      repeat (3) @(posedge clk);
      #2;
      check("R1", "step in reset", step, 0);
      check("R1", "word in reset", ctrl_word, 16'h0003);
      @(negedge clk); #2;
      rst = 1'b0;
      mon_on = 1'b1;
   endtask

   task automatic t_nop;
      flags_in = 2'b11;
      fetch_chk(4'd0);
      step_chk(2, 16'h8000, 0, "R4");
      back_to_t0("R4");
      flags_in = 2'b00;
   endtask

   task automatic t_load;
      fetch_chk(4'd1);
      bus_in = 4'd7;
      step_chk(2, 16'h0003, 0, "R10");
      step_chk(3, 16'h0034, 0, "R10");
      step_chk(4, 16'h8000, 0, "R4");
      back_to_t0("R4");
   endtask

   task automatic t_add;
      fetch_chk(4'd2);
      step_chk(2, 16'h0920, 0, "R10");
      step_chk(3, 16'h8000, 0, "R10");
      check("R9", "flag clock total", tot2, 1);
      check("R9", "write clock total", tot0, 0);
      check("R9", "stack clock total", tot1, 0);
   endtask

   task automatic t_store;
      fetch_chk(4'd3);
      step_chk(2, 16'h0240, 0, "R10");
      step_chk(3, 16'h8000, 0, "R10");
      check("R9", "write clock total", tot0, 1);
      check("R9", "flag clock total", tot2, 0);
   endtask

   task automatic t_push;
      fetch_chk(4'd7);
      step_chk(2, 16'h0440, 0, "R10");
      step_chk(3, 16'h8000, 0, "R10");
      check("R9", "stack clock total", tot1, 1);
   endtask

   task automatic t_jump(input logic [3:0] op, input logic [1:0] fl,
                         input logic [15:0] w3, input bit pl);
      fetch_chk(op);
      step_chk(2, 16'h0003, 0, "R10");
      flags_in = fl;
      step_chk(3, w3, pl, "R8");
      step_chk(4, 16'h8000, 0, "R7");
      flags_in = 2'b00;
   endtask

   task automatic t_long;
      fetch_chk(4'd8);
      step_chk(2, 16'h0800, 0, "R3");
      for (int s = 3; s < 8; s++) step_chk(s, 16'h0000, 0, "R3");
      back_to_t0("R3");
      check("R9", "flag clock total long", tot2, 1);
   endtask

   task automatic t_bus_late;
      bus_in = 4'd3;
      step_chk(0, 16'h0003, 0, "R5");
      @(posedge clk); #2;
      check("R5", "T1 word", ctrl_word, 16'h001C);
      bus_in = 4'd2;
      @(negedge clk); #1;
      step_chk(2, 16'h0240, 0, "R5");
      bus_in = 4'd8;
      step_chk(3, 16'h8000, 0, "R5");
      back_to_t0("R5");
   endtask

   task automatic t_unknown;
      fetch_chk(4'd15);
      step_chk(2, 16'h8000, 0, "R10");
      back_to_t0("R4");
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      t_reset;
      t_nop;
      t_load;
      t_add;
      t_store;
      t_push;
      t_jump(4'd4, 2'b00, 16'h4004, 1'b1);
      t_jump(4'd5, 2'b00, 16'h1004, 1'b0);
      t_jump(4'd5, 2'b01, 16'h1004, 1'b1);
      t_jump(4'd6, 2'b01, 16'h2004, 1'b0);
      t_jump(4'd6, 2'b10, 16'h2004, 1'b1);
      t_long;
      t_bus_late;
      t_unknown;
      done = 1'b1;
      summary;
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         summary;
         $finish;
      end
   end
endmodule